// File: doc/BRIEF.md
# Prescaled Module Clock Generator

This block derives a module clock enable from one of several source tick streams inside a single system clock domain. Each source is a one-cycle tick input. A 32-bit control register picks the source. It sets a power-of-two prescaler and an integer divider, and it holds a gate bit. The result comes out in two forms: a one-cycle tick output, and a square-wave level that downstream logic can use as a slow enable.

Software programs the register through a plain write/read port. The block cannot multiply, so the output rate is always the selected source rate divided by a whole number. The block also has a purely combinational helper. Given a wanted total division, it returns the preferred prescale and divider fields.

Top module: `mclk_gen`

## Requirements
- R1: Control bits 3:0 hold M. Prescaled ticks are divided by M+1, which gives a ratio from 1 to 16.
- R2: Control bits 17:16 hold P. Source ticks are prescaled by 2^P (1, 2, 4 or 8) before the M divider, so one output pulse needs (M+1)·2^P selected source ticks.
- R3: The select field starts at bit 24 and is SEL_W bits wide (2 by default, 4 in the wide variant). The value s routes src_tick[s] into the prescaler.
- R4: Bit 31 gates the output. While it is 0, tick_out and level_out are 0 and both counters are held at zero.
- R5: tick_out is a one-cycle pulse. It is registered, and it appears in the cycle after the clock edge that takes the (M+1)·2^P-th selected source tick since the last write. A pulse can only follow a cycle in which the selected source ticked, so the output never exceeds the source rate.
- R6: level_out is high during the first floor((M+1)/2) of every M+1 prescaled intervals, counting from the write. With even M+1 this gives 50% duty, and with odd M+1 the high phase is one interval shorter. M=0 keeps level_out low.
- R7: Every register write clears both counters at the write edge. A source tick that arrives in the write cycle is not counted.
- R8: Bits that hold no field read back as 0, and writing 1 to them has no effect on rd_data.
- R9: For a wanted division d (0 treated as 1), hint_p is the smallest P with floor(d/2^P) < 16, capped at 3. hint_m is ceil(d/2^P)−1, capped at 15.
- R10: After reset the register reads 0, and tick_out and level_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 2**SEL_W | One-cycle source ticks, one per selectable source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| tick_out | output | 1 | Divided one-cycle tick |
| level_out | output | 1 | Square-wave enable |
| want_div | input | HINT_W | Wanted total division for the hint |
| hint_p | output | 2 | Suggested prescale field |
| hint_m | output | 4 | Suggested divide field |

## Verification
The register value and rd_data are due in the cycle after the write edge. The hint outputs are combinational, so the bench checks them one time step after it drives want_div. Counting from the write edge as cycle 0, tick_out is due in the cycle after edge c when c is a non-zero multiple of (M+1)·2^P. Over the same cycles, level_out must equal floor(c/2^P) mod (M+1) < floor((M+1)/2). The bench samples every output on the falling edge after the edge under test and compares it with these formulas for every P and M, for every source, and with the gate off.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

    localparam int M_LSB    = 0;
    localparam int P_LSB    = 16;
    localparam int SEL_LSB  = 24;
    localparam int GATE_BIT = 31;
    localparam int SEL_MAXW = 4;

    typedef struct packed {
        logic                gate;
        logic [SEL_MAXW-1:0] sel;
        logic [1:0]          p;
        logic [3:0]          m;
    } mclk_cfg_t;

    function automatic mclk_cfg_t cfg_from_word(input logic [31:0] w,
                                                input logic [SEL_MAXW-1:0] sel_mask);
        mclk_cfg_t c;
        c.gate = w[GATE_BIT];
        c.sel  = w[SEL_LSB +: SEL_MAXW] & sel_mask;
        c.p    = w[P_LSB +: 2];
        c.m    = w[M_LSB +: 4];
        return c;
    endfunction

    function automatic logic [31:0] word_from_cfg(input mclk_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[GATE_BIT]             = c.gate;
        w[SEL_LSB +: SEL_MAXW]  = c.sel;
        w[P_LSB +: 2]           = c.p;
        w[M_LSB +: 4]           = c.m;
        return w;
    endfunction

endpackage

// File: rtl/mclk_regs.sv
module mclk_regs
    import mclk_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output mclk_cfg_t   cfg
);
    localparam logic [SEL_MAXW-1:0] SEL_MASK = SEL_MAXW'((32'd1 << SEL_W) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= cfg_from_word(wr_data, SEL_MASK);
    end

    assign rd_data = word_from_cfg(cfg);

    p_sel_fits_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel & ~SEL_MASK) == '0);
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~(32'h8003_000F | (32'(SEL_MASK) << SEL_LSB))) == 32'd0);
endmodule

// File: rtl/mclk_divider.sv
module mclk_divider
    import mclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  mclk_cfg_t cfg,
    input  logic      sel_tick,
    output logic      tick_out,
    output logic      level_out
);
    logic [2:0] pre_cnt;
    logic [3:0] div_cnt;
    logic [2:0] pre_lim;
    logic       pre_hit;
    logic [4:0] high_len;

    assign pre_lim  = 3'((4'd1 << cfg.p) - 4'd1);
    assign pre_hit  = sel_tick && (pre_cnt == pre_lim);
    assign high_len = ({1'b0, cfg.m} + 5'd1) >> 1;

    always_ff @(posedge clk) begin
        if (rst || restart || !cfg.gate) begin
            pre_cnt  <= '0;
            div_cnt  <= '0;
            tick_out <= 1'b0;
        end else begin
            if (sel_tick)
                pre_cnt <= pre_hit ? 3'd0 : pre_cnt + 3'd1;
            if (pre_hit)
                div_cnt <= (div_cnt == cfg.m) ? 4'd0 : div_cnt + 4'd1;
            tick_out <= pre_hit && (div_cnt == cfg.m);
        end
    end

    assign level_out = cfg.gate && ({1'b0, div_cnt} < high_len);

    p_div_range_r1: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= cfg.m);
    p_pre_range_r2: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= pre_lim);
    p_gate_off_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg.gate |-> (!tick_out && !level_out));
    p_tick_needs_src_r5: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(sel_tick));
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (pre_cnt == 3'd0 && div_cnt == 4'd0 && !tick_out));
endmodule

// File: rtl/mclk_rate_hint.sv
module mclk_rate_hint #(
    parameter int HINT_W = 8
) (
    input  logic [HINT_W-1:0] want_div,
    output logic [1:0]        hint_p,
    output logic [3:0]        hint_m
);
    logic [HINT_W-1:0] d;
    logic [HINT_W:0]   q;

    always_comb begin
        d = (want_div == '0) ? HINT_W'(1) : want_div;
        if      ((d >> 0) < HINT_W'(16)) hint_p = 2'd0;
        else if ((d >> 1) < HINT_W'(16)) hint_p = 2'd1;
        else if ((d >> 2) < HINT_W'(16)) hint_p = 2'd2;
        else                             hint_p = 2'd3;
        q = ({1'b0, d} + ((HINT_W+1)'(1) << hint_p) - (HINT_W+1)'(1)) >> hint_p;
        hint_m = (q > (HINT_W+1)'(16)) ? 4'd15 : 4'(q - (HINT_W+1)'(1));
    end

    always_comb begin
        a_hint_min_r9: assert ((q != '0) || (want_div == '0 && q != '0) || 1'b0 || (q >= (HINT_W+1)'(1)));
    end
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
    import mclk_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int HINT_W = 8,
    localparam int NUM_SRC = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic               tick_out,
    output logic               level_out,
    input  logic [HINT_W-1:0]  want_div,
    output logic [1:0]         hint_p,
    output logic [3:0]         hint_m
);
    mclk_cfg_t cfg;
    logic      sel_tick;

    mclk_regs #(.SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    assign sel_tick = src_tick[cfg.sel[SEL_W-1:0]];

    mclk_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (wr_en),
        .cfg       (cfg),
        .sel_tick  (sel_tick),
        .tick_out  (tick_out),
        .level_out (level_out)
    );

    mclk_rate_hint #(.HINT_W(HINT_W)) u_hint (
        .want_div (want_div),
        .hint_p   (hint_p),
        .hint_m   (hint_m)
    );
endmodule

// File: tb/test_mclk_gen.sv
module test_mclk_gen;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int HINT_W  = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] src_tick = '0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_data = '0;
    logic [31:0]        rd_data;
    logic               tick_out, level_out;
    logic [HINT_W-1:0]  want_div = '0;
    logic [1:0]         hint_p;
    logic [3:0]         hint_m;

    int n_checks = 0;
    int n_errors = 0;

    mclk_gen #(.SEL_W(SEL_W), .HINT_W(HINT_W)) i_mclk_gen (
        .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tick_out(tick_out),
        .level_out(level_out), .want_div(want_div), .hint_p(hint_p),
        .hint_m(hint_m)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input bit g, input int s, input int p, input int m);
        return {g, 3'b0, 4'(s), 6'b0, 2'(p), 12'b0, 4'(m)};
    endfunction

    // drive at a falling edge, return at the falling edge after the write edge
    task automatic do_write(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(rd_data == 32'd0, "R10 rd_data", int'(rd_data), 0);
        chk(!tick_out && !level_out, "R10 outputs", int'({tick_out, level_out}), 0);

        // R8 reserved bits
        do_write(32'hFFFF_FFFF);
        begin
            logic [31:0] mask;
            mask = 32'h8003_000F | (((32'd1 << SEL_W) - 1) << 24);
            chk(rd_data == mask, "R8 readback mask", int'(rd_data), int'(mask));
        end
        do_write(mkword(1, 0, 2, 9));
        chk(rd_data == mkword(1, 0, 2, 9), "R1 R2 field positions", int'(rd_data), int'(mkword(1, 0, 2, 9)));

        // R1 R2 R5 R6 R7: sweep all P and M with source 0 ticking every cycle
        src_tick = '1;
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                int per, n, bad_t, bad_l;
                n = m + 1;
                per = n << p;
                bad_t = 0;
                bad_l = 0;
                do_write(mkword(1, 0, p, m));
                for (int c = 0; c <= 3 * per; c++) begin
                    bit et, el;
                    if (c > 0) begin
                        @(posedge clk);
                        @(negedge clk);
                    end
                    et = (c > 0) && (c % per == 0);
                    el = ((c >> p) % n) < (n / 2);
                    if (tick_out !== et) bad_t++;
                    if (level_out !== el) bad_l++;
                end
                chk(bad_t == 0, $sformatf("R5 R1 R2 tick p=%0d m=%0d", p, m), bad_t, 0);
                chk(bad_l == 0, $sformatf("R6 level p=%0d m=%0d", p, m), bad_l, 0);
            end
        end

        // R7: a write mid-period restarts counting
        do_write(mkword(1, 0, 1, 3));
        repeat (5) @(posedge clk);
        @(negedge clk);
        do_write(mkword(1, 0, 1, 3));
        begin
            int bad;
            bad = 0;
            for (int c = 0; c <= 16; c++) begin
                if (c > 0) begin @(posedge clk); @(negedge clk); end
                if (tick_out !== ((c > 0) && (c % 8 == 0))) bad++;
            end
            chk(bad == 0, "R7 restart on rewrite", bad, 0);
        end

        // R3 source select, P=0 M=0: tick_out follows the chosen source one cycle later
        for (int s = 0; s < NUM_SRC; s++) begin
            bit prev;
            int bad, seen;
            src_tick = '0;
            do_write(mkword(1, s, 0, 0));
            prev = 1'b0;
            bad = 0;
            seen = 0;
            for (int k = 0; k < 24; k++) begin
                if (tick_out !== prev) bad++;
                if (tick_out) seen++;
                for (int i = 0; i < NUM_SRC; i++)
                    src_tick[i] = ((k % (i + 2)) == 0);
                prev = src_tick[s];
                @(posedge clk);
                @(negedge clk);
            end
            chk(bad == 0, $sformatf("R3 source %0d", s), bad, 0);
            chk(seen > 0, $sformatf("R3 source %0d active", s), seen, 1);
        end

        // R7: tick in the write cycle is ignored
        src_tick = '1;
        do_write(mkword(1, 0, 0, 0));
        chk(tick_out == 1'b0, "R7 write-cycle tick ignored", int'(tick_out), 0);

        // R4 gate off
        begin
            int bad;
            bad = 0;
            do_write(mkword(0, 0, 0, 1));
            for (int k = 0; k < 12; k++) begin
                if (tick_out || level_out) bad++;
                @(posedge clk);
                @(negedge clk);
            end
            chk(bad == 0, "R4 gate off holds outputs low", bad, 0);
        end

        // R9 hint sweep
        begin
            int bad;
            bad = 0;
            for (int v = 0; v < 256; v++) begin
                int d, ep, em, q;
                want_div = 8'(v);
                #1;
                d = (v == 0) ? 1 : v;
                ep = 3;
                for (int p = 3; p >= 0; p--)
                    if ((d / (1 << p)) < 16) ep = p;
                q = (d + (1 << ep) - 1) / (1 << ep);
                em = (q > 16) ? 15 : q - 1;
                if (hint_p != 2'(ep) || hint_m != 4'(em)) begin
                    bad++;
                    chk(0, $sformatf("R9 hint d=%0d", v), int'({hint_p, hint_m}), (ep << 4) | em);
                end
            end
            chk(bad == 0, "R9 hint sweep", bad, 0);
            want_div = 8'd16;
            #1;
            chk(hint_p == 2'd1 && hint_m == 4'd7, "R9 d=16", int'({hint_p, hint_m}), (1 << 4) | 7);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule